// File: doc/BRIEF.md
# Transmit Frame Check Sequence and Padding Stage

This block sits on the transmit byte path of an Ethernet MAC, ahead of the line encoder. Frames arrive one byte per transfer on a valid/ready interface that marks the first and the last byte. With the first byte comes a 2-bit control code that tells the block what to do at the end of that frame. It can fill a short frame with zero bytes up to the minimum length and then add a CRC-32. It can add the CRC without filling. It can pass the frame through untouched. It can also drop the frame's own last four bytes and put a freshly computed CRC in their place.

The output uses the same valid/ready interface with first and last markers. When the downstream side withholds ready, the block holds the input back and no byte is lost. In replace mode the block keeps the four most recent bytes back inside itself. It does this because the end of the frame is not known until the last byte arrives.

Top module: `tx_fcs_inserter`

## Requirements
- R1: After reset, with no input offered, `out_valid`, `out_sof` and `out_eof` are low.
- R2: Code 0 (pad and append) on a frame shorter than MIN_LEN (60) bytes emits the data, then zero bytes up to 60 bytes, then 4 CRC bytes computed over data and padding, 64 bytes in all.
- R3: Code 0 on a frame of 60 bytes or more emits the data unchanged followed by 4 CRC bytes, with no padding.
- R4: Code 1 (append only) emits the data unchanged followed by 4 CRC bytes, and never pads, even for short frames.
- R5: Code 2 (bypass) emits exactly the input bytes, with `out_eof` on the last data byte and no added bytes.
- R6: Code 3 (replace) on a frame of N > 4 bytes emits the first N-4 bytes followed by 4 CRC bytes computed over those N-4 bytes.
- R7: The CRC is the reflected CRC-32 with polynomial 0x04C11DB7. The register starts at all ones and the result is complemented. It is sent least significant byte first, so the 9 ASCII bytes "123456789" get the tail bytes 26 39 F4 CB.
- R8: The control code is taken from `in_mode` on the byte that carries `in_sof`. Changes to `in_mode` on later bytes of the same frame have no effect on the output.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold until the transfer, and no input byte is lost or duplicated. Input is refused while padding or CRC bytes are being emitted.
- R10: `out_sof` is high on the first output byte of each frame only, and `out_eof` on the last only.
- R11: Code 3 on a frame of 4 bytes or fewer emits only the 4 CRC bytes of an empty payload: 00 00 00 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| in_mode | input | 2 | Per-frame control code, read with the first byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is first of frame |
| out_eof | output | 1 | Output byte is last of frame |

## Verification
The assertions assume that the source follows valid/ready rules. Once `in_valid` is raised with a byte, that byte and its markers stay unchanged until it is accepted. Each frame opens with `in_sof` and closes with `in_eof`, and the source never lowers `in_valid` partway through a frame. The stability property on stalled output depends on this. The bench meets it by driving each byte with `in_valid` held high until it sees acceptance. It advances to the next byte only after that acceptance, and it offers every byte of a frame back to back. Where a vector calls for it, it lowers `out_ready` on a fixed cadence to exercise stalls in all four modes.

// File: rtl/tx_fcs_pkg.sv
package tx_fcs_pkg;

  localparam int FCS_BYTES = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    FCS_PAD_APPEND = 2'd0,
    FCS_APPEND     = 2'd1,
    FCS_BYPASS     = 2'd2,
    FCS_REPLACE    = 2'd3
  } fcs_mode_e;

  typedef enum logic [1:0] {
    PH_BODY = 2'd0,
    PH_PAD  = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  // One byte of reflected CRC-32, bit 0 of the byte first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/fcs_crc_acc.sv
module fcs_crc_acc
  import tx_fcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  logic [31:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= CRC_SEED;
    else if (clear) state_q <= CRC_SEED;
    else if (upd)   state_q <= crc32_byte(state_q, din);
  end

  assign fcs = ~state_q;
endmodule

// File: rtl/fcs_hold_line.sv
module fcs_hold_line #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  stage_q [DEPTH];
  logic [FW-1:0] fill_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage_q[i] <= '0;
      else if (push) stage_q[i] <= (i == 0) ? din : stage_q[(i == 0) ? 0 : i - 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 fill_q <= '0;
    else if (flush)             fill_q <= '0;
    else if (push && !full)     fill_q <= fill_q + 1'b1;
  end

  assign full = (fill_q == FW'(DEPTH));
  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/fcs_len_track.sv
module fcs_len_track #(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic short_after
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (clear)                       cnt_q <= '0;
    else if (inc && (int'(cnt_q) < LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  // True when the byte counted now still leaves the frame below LIMIT.
  assign short_after = (int'(cnt_q) + 1) < LIMIT;
endmodule

// File: rtl/tx_fcs_inserter.sv
module tx_fcs_inserter
  import tx_fcs_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [1:0] in_mode,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  localparam int TIW = $clog2(FCS_BYTES);

  phase_e          phase_q, phase_d;
  fcs_mode_e       mode_q, eff_mode;
  logic            in_frame;
  logic            sent_any_q;
  logic [TIW-1:0]  tail_idx_q;

  logic            in_fire, out_fire, body_end, frame_done;
  logic            pad_active, tail_active, data_out;
  logic [1:0]      cur_mode;
  logic            hold_full, hold_push;
  logic [7:0]      hold_dout;
  logic [31:0]     fcs;
  logic            short_after;

  assign eff_mode    = in_frame ? mode_q : fcs_mode_e'(in_mode);
  assign cur_mode    = mode_q;
  assign pad_active  = (phase_q == PH_PAD);
  assign tail_active = (phase_q == PH_TAIL);

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_eof   = 1'b0;
    in_ready  = 1'b0;
    unique case (phase_q)
      PH_BODY: begin
        if (eff_mode == FCS_REPLACE) begin
          if (!hold_full) begin
            in_ready = 1'b1;
          end else begin
            out_valid = in_valid;
            out_data  = hold_dout;
            in_ready  = out_ready;
          end
        end else begin
          out_valid = in_valid;
          out_data  = in_data;
          in_ready  = out_ready;
          out_eof   = in_eof && (eff_mode == FCS_BYPASS);
        end
      end
      PH_PAD: begin
        out_valid = 1'b1;
      end
      PH_TAIL: begin
        out_valid = 1'b1;
        out_data  = fcs[8*tail_idx_q +: 8];
        out_eof   = (tail_idx_q == TIW'(FCS_BYTES - 1));
      end
      default: ;
    endcase
  end

  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign body_end   = (phase_q == PH_BODY) && in_fire && in_eof;
  assign frame_done = out_fire && out_eof;
  assign data_out   = out_fire && (phase_q != PH_TAIL);
  assign out_sof    = out_valid && !sent_any_q;
  assign hold_push  = (phase_q == PH_BODY) && (eff_mode == FCS_REPLACE) && in_fire;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_BODY: if (body_end) begin
        if (eff_mode == FCS_BYPASS)                         phase_d = PH_BODY;
        else if (eff_mode == FCS_PAD_APPEND && short_after) phase_d = PH_PAD;
        else                                                phase_d = PH_TAIL;
      end
      PH_PAD:  if (out_fire && !short_after) phase_d = PH_TAIL;
      PH_TAIL: if (frame_done)               phase_d = PH_BODY;
      default: phase_d = PH_BODY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_BODY;
      mode_q     <= FCS_PAD_APPEND;
      in_frame   <= 1'b0;
      sent_any_q <= 1'b0;
      tail_idx_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (!in_frame && in_fire) mode_q <= fcs_mode_e'(in_mode);
      if (frame_done)   in_frame <= 1'b0;
      else if (in_fire) in_frame <= 1'b1;
      if (frame_done)    sent_any_q <= 1'b0;
      else if (out_fire) sent_any_q <= 1'b1;
      if (tail_active && out_fire) tail_idx_q <= tail_idx_q + 1'b1;
    end
  end

  fcs_crc_acc u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(frame_done),
    .upd  (data_out),
    .din  (out_data),
    .fcs  (fcs)
  );

  fcs_hold_line #(.DEPTH(FCS_BYTES), .W(8)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(frame_done),
    .push (hold_push),
    .din  (in_data),
    .full (hold_full),
    .dout (hold_dout)
  );

  fcs_len_track #(.LIMIT(MIN_LEN)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (frame_done),
    .inc        (data_out),
    .short_after(short_after)
  );
endmodule

// File: rtl/tx_fcs_checker.sv
module tx_fcs_checker #(
  parameter int MIN_LEN   = 60,
  parameter int FCS_BYTES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       in_frame,
  input logic [1:0] cur_mode,
  input logic       pad_active,
  input logic       tail_active,
  input logic       frame_done
);
  logic [11:0] obytes_q;
  logic        ofire;

  assign ofire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 obytes_q <= '0;
    else if (ofire && out_eof)  obytes_q <= '0;
    else if (ofire && obytes_q != 12'hFFF) obytes_q <= obytes_q + 1'b1;
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_tail_blocks_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_active || pad_active) |-> !in_ready);

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pad_active && out_valid |-> out_data == 8'h00);

  p_min_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ofire && out_eof && cur_mode == 2'd0 |-> int'(obytes_q) >= MIN_LEN + FCS_BYTES - 1);

  p_sof_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ofire && out_sof |-> obytes_q == 12'd0);

  p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame && !frame_done |=> $stable(cur_mode));
endmodule

bind tx_fcs_inserter tx_fcs_checker #(.MIN_LEN(MIN_LEN), .FCS_BYTES(tx_fcs_pkg::FCS_BYTES)) u_fcs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_sof    (out_sof),
  .out_eof    (out_eof),
  .in_frame   (in_frame),
  .cur_mode   (cur_mode),
  .pad_active (pad_active),
  .tail_active(tail_active),
  .frame_done (frame_done)
);

// File: tb/test_tx_fcs_inserter.sv
module test_tx_fcs_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [1:0] in_mode = 2'd0;
  logic       out_valid, out_sof, out_eof;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  tx_fcs_inserter i_tx_fcs_inserter (.*);

  int checks = 0, fails = 0;

  // {flip, stall, mode[1:0], len[7:0], seed[7:0]}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 8'd10, 8'h11},
    {1'b0, 1'b1, 2'd0, 8'd59, 8'h22},
    {1'b0, 1'b0, 2'd0, 8'd60, 8'h33},
    {1'b0, 1'b1, 2'd0, 8'd75, 8'h44},
    {1'b0, 1'b0, 2'd1, 8'd10, 8'h55},
    {1'b0, 1'b1, 2'd1, 8'd64, 8'h66},
    {1'b0, 1'b0, 2'd2, 8'd12, 8'h77},
    {1'b0, 1'b1, 2'd2, 8'd1,  8'h88},
    {1'b0, 1'b0, 2'd3, 8'd20, 8'h99},
    {1'b0, 1'b1, 2'd3, 8'd5,  8'hAA},
    {1'b0, 1'b0, 2'd3, 8'd3,  8'hBB},
    {1'b1, 1'b0, 2'd0, 8'd20, 8'hCC},
    {1'b1, 1'b1, 2'd3, 8'd30, 8'hDD}
  };

  logic [7:0] src  [128];
  logic [7:0] expd [128];
  logic [7:0] gdat [160];
  logic       gsof [160];
  logic       geof [160];
  int exp_n, got_n, stall_bad;

  // Bitwise serial form of the reflected CRC, independent of the design's helper.
  function automatic logic [31:0] ref_crc(input int n, input int from_exp);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = from_exp ? expd[k] : src[k];
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ b[i];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic build_expect(input int mode, input int len);
    logic [31:0] f;
    int body;
    exp_n = 0;
    if (mode == 3) body = (len > 4) ? len - 4 : 0;
    else body = len;
    for (int k = 0; k < body; k++) begin expd[exp_n] = src[k]; exp_n++; end
    if (mode == 0) while (exp_n < 60) begin expd[exp_n] = 8'h00; exp_n++; end
    if (mode != 2) begin
      f = ref_crc(exp_n, 1);
      for (int k = 0; k < 4; k++) begin expd[exp_n] = f[8*k +: 8]; exp_n++; end
    end
  endtask

  task automatic run_frame(input int mode, input int len, input bit stall, input bit flip);
    int idx = 0, cyc = 0;
    bit done = 0, prev_stall = 0;
    logic [7:0] prev_data = 8'h00;
    got_n = 0; stall_bad = 0;
    while (!done && cyc < 600) begin
      @(negedge clk);
      out_ready = !(stall && (cyc % 3 == 1));
      if (idx < len) begin
        in_valid = 1'b1;
        in_data  = src[idx];
        in_sof   = (idx == 0);
        in_eof   = (idx == len - 1);
        in_mode  = (idx != 0 && flip) ? ~2'(mode) : 2'(mode);
      end else begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
      #1;
      if (prev_stall && !(out_valid && out_data == prev_data)) stall_bad++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready && got_n < 160) begin
        gdat[got_n] = out_data; gsof[got_n] = out_sof; geof[got_n] = out_eof;
        got_n++;
        if (out_eof) done = 1;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; out_ready = 1'b1;
  endtask

  task automatic check_frame(input string tag, input bit stall);
    int bad = -1, fbad = 0;
    checks++;
    if (got_n != exp_n) begin
      fails++; $display("FAIL %s length: actual %0d expected %0d", tag, got_n, exp_n);
    end
    checks++;
    for (int k = 0; k < exp_n && k < got_n; k++)
      if (bad < 0 && gdat[k] !== expd[k]) bad = k;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s byte %0d: actual %02h expected %02h", tag, bad, gdat[bad], expd[bad]);
    end
    checks++;
    for (int k = 0; k < got_n; k++)
      if (gsof[k] !== (k == 0) || geof[k] !== (k == got_n - 1)) fbad++;
    if (fbad != 0) begin
      fails++; $display("FAIL R10 markers: actual %0d bad bytes expected 0", fbad);
    end
    if (stall) begin
      checks++;
      if (stall_bad != 0) begin
        fails++; $display("FAIL R9 stalled output changed: actual %0d expected 0", stall_bad);
      end
    end
  endtask

  function automatic string req_of(input int mode, input int len, input bit flip);
    if (flip) return "R8";
    case (mode)
      0: return (len < 60) ? "R2" : "R3";
      1: return "R4";
      2: return "R5";
      default: return (len <= 4) ? "R11" : "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1 out_valid in reset: actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    checks++;
    if ({out_valid, out_sof, out_eof} !== 3'b000) begin
      fails++; $display("FAIL R1 idle outputs: actual %b expected 000", {out_valid, out_sof, out_eof});
    end

    for (int v = 0; v < NV; v++) begin
      logic [19:0] e = VEC[v];
      int mode = int'(e[17:16]);
      int len  = int'(e[15:8]);
      for (int k = 0; k < len; k++) src[k] = e[7:0] + 8'(k * 13);
      build_expect(mode, len);
      run_frame(mode, len, e[18], e[19]);
      check_frame(req_of(mode, len, e[19]), e[18]);
    end

    // R7: known check value for "123456789", code 1
    for (int k = 0; k < 9; k++) src[k] = 8'h31 + 8'(k);
    build_expect(1, 9);
    run_frame(1, 9, 1'b0, 1'b0);
    checks++;
    if (got_n != 13 || {gdat[12], gdat[11], gdat[10], gdat[9]} !== 32'hCBF43926) begin
      fails++;
      $display("FAIL R7 check value: actual %02h%02h%02h%02h expected cbf43926",
               gdat[12], gdat[11], gdat[10], gdat[9]);
    end

    // R11: replace with exactly four bytes gives an all-zero tail
    for (int k = 0; k < 4; k++) src[k] = 8'hF0 + 8'(k);
    build_expect(3, 4);
    run_frame(3, 4, 1'b0, 1'b0);
    checks++;
    if (got_n != 4 || {gdat[0], gdat[1], gdat[2], gdat[3]} !== 32'h0) begin
      fails++;
      $display("FAIL R11 empty tail: actual %0d bytes %02h%02h%02h%02h expected 4 bytes 00000000",
               got_n, gdat[0], gdat[1], gdat[2], gdat[3]);
    end

    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1 idle after frames: actual %b expected 0", out_valid);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule